// File: doc/BRIEF.md
# Lockable flash control register

This block is the software-facing control register of an embedded flash controller. On a simple 32-bit register bus (address, write enable, write data, combinational read data) it holds the operation selectors that a flash timing engine acts upon: program, page erase, mass erase, option program and option erase. It also holds a start trigger, two interrupt enables and an option-reload trigger. The engine reports busy, end-of-operation and two error flags back. The block turns these into a registered interrupt request, and it turns the reload trigger into a system-reset request.

All of this sits behind a lock. After reset the register is locked, and only a lock-set write is honoured. Software opens it by writing two parameterised keys, in order, to a key register. A wrong key or a wrong order disables any further unlock until the next reset. A second key pair, written to an option-key register while unlocked, grants option write access. Software can withdraw that access but cannot grant it directly.

Register map by byte address: unlock key at 0x0, option key at 0x4, control word at 0x8. The key registers read as zero.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the control word at 0x8 reads 0x0000_0080 (lock bit 7 set, all other bits zero), and the interrupt and reset-request outputs are 0.
- R2: Bits 31:14, 11, 8 and 3 of the control word always read 0, and writes to them are ignored.
- R3: Writing 1 to bit 7 sets the lock. Writing 0 to bit 7 never clears it.
- R4: Writing KEY1 and then KEY2 to address 0x0, while locked and not disabled, clears the lock.
- R5: Any other key write while locked (a wrong value, KEY2 without a preceding KEY1, or KEY1 twice) keeps the lock set and disables unlocking until the next reset.
- R6: While locked, control writes change no bit except setting the lock.
- R7: Bit 6 (start) is set only by writing 1 to it while unlocked. Writing 0 does not clear it. It clears on the clock edge at which a fall of the busy input is detected.
- R8: Bit 9 (option write enable) is set only by writing OPT_KEY1 then OPT_KEY2 to address 0x4 while unlocked, and writes there while locked are ignored. Writing 0 to bit 9 clears it, and writing 1 does nothing.
- R9: The operation selectors are at bit 0 (program), bit 1 (page erase), bit 2 (mass erase), bit 4 (option program) and bit 5 (option erase). Each one is mirrored on its own output.
- R10: The interrupt output is registered with one cycle of latency. It equals (end-of-operation AND bit 12) OR ((program error OR write-protect error) AND bit 10).
- R11: Writing 1 to bit 13 while unlocked sets bit 13 and raises the system-reset request output. Both stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_busy | input | 1 | Engine busy |
| eng_eop | input | 1 | End-of-operation flag |
| eng_prog_err | input | 1 | Programming error flag |
| eng_wprot_err | input | 1 | Write-protection error flag |
| op_prog | output | 1 | Program selected |
| op_page_erase | output | 1 | Page erase selected |
| op_mass_erase | output | 1 | Mass erase selected |
| op_opt_prog | output | 1 | Option program selected |
| op_opt_erase | output | 1 | Option erase selected |
| op_start | output | 1 | Start trigger |
| locked | output | 1 | Lock state |
| opt_wr_en | output | 1 | Option write enable |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | System reset request |

## Verification
On every cycle the assertions check four things. The lock falls only right after a KEY2 write. The unlock-disabled state never leaves before reset. Locked cycles leave the control bits unchanged. Option write enable rises only after an OPT_KEY2 write. They also check that a detected busy fall clears start, and that the interrupt stays low while both enables are off. The exact read values, the reserved-bit masking, each selector position, the recovery from a disabled unlock through reset, and the exact one-cycle interrupt timing for each flag combination are shown only by the bench scenarios.

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs #(
  parameter int ADDR_W = 4,
  parameter logic [31:0] KEY1 = 32'h3C5A_96E1,
  parameter logic [31:0] KEY2 = 32'hC3A5_691E,
  parameter logic [31:0] OPT_KEY1 = 32'h0F1E_2D3C,
  parameter logic [31:0] OPT_KEY2 = 32'hF0E1_D2C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_eop,
  input  logic              eng_prog_err,
  input  logic              eng_wprot_err,
  output logic              op_prog,
  output logic              op_page_erase,
  output logic              op_mass_erase,
  output logic              op_opt_prog,
  output logic              op_opt_erase,
  output logic              op_start,
  output logic              locked,
  output logic              opt_wr_en,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OKEY = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8);

  logic wr_key, wr_okey, wr_ctrl, open_wr;
  logic key_armed, key_dead, okey_armed;
  logic eop_ie, err_ie, busy_q;

  assign wr_key  = bus_we && bus_addr == A_KEY;
  assign wr_okey = bus_we && bus_addr == A_OKEY;
  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign open_wr = wr_ctrl && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b1;
      key_armed <= 1'b0;
      key_dead  <= 1'b0;
    end else begin
      if (wr_ctrl && bus_wdata[7]) locked <= 1'b1;
      if (wr_key && locked && !key_dead) begin
        if (key_armed && bus_wdata == KEY2) begin
          locked    <= 1'b0;
          key_armed <= 1'b0;
        end else if (!key_armed && bus_wdata == KEY1) begin
          key_armed <= 1'b1;
        end else begin
          key_dead  <= 1'b1;
          key_armed <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      okey_armed <= 1'b0;
      opt_wr_en  <= 1'b0;
    end else begin
      if (wr_okey && !locked) begin
        if (okey_armed && bus_wdata == OPT_KEY2) begin
          opt_wr_en  <= 1'b1;
          okey_armed <= 1'b0;
        end else begin
          okey_armed <= bus_wdata == OPT_KEY1;
        end
      end else if (open_wr && !bus_wdata[9]) begin
        opt_wr_en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {op_prog, op_page_erase, op_mass_erase, op_opt_prog, op_opt_erase} <= '0;
      {eop_ie, err_ie, sys_rst_req, op_start, busy_q, irq} <= '0;
    end else begin
      busy_q <= eng_busy;
      irq    <= (eng_eop && eop_ie) || ((eng_prog_err || eng_wprot_err) && err_ie);
      if (open_wr) begin
        op_prog       <= bus_wdata[0];
        op_page_erase <= bus_wdata[1];
        op_mass_erase <= bus_wdata[2];
        op_opt_prog   <= bus_wdata[4];
        op_opt_erase  <= bus_wdata[5];
        err_ie        <= bus_wdata[10];
        eop_ie        <= bus_wdata[12];
        if (bus_wdata[13]) sys_rst_req <= 1'b1;
      end
      if (open_wr && bus_wdata[6]) op_start <= 1'b1;
      else if (busy_q && !eng_busy) op_start <= 1'b0;
    end
  end

  assign bus_rdata = (bus_addr == A_CTRL) ?
    {18'b0, sys_rst_req, eop_ie, 1'b0, err_ie, opt_wr_en, 1'b0, locked, op_start,
     op_opt_erase, op_opt_prog, 1'b0, op_mass_erase, op_page_erase, op_prog} : 32'b0;

  p_unlock_needs_key2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr_key && bus_wdata == KEY2));

  p_dead_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    key_dead |=> key_dead && locked);

  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({op_prog, op_page_erase, op_mass_erase, op_opt_prog, op_opt_erase,
                        eop_ie, err_ie, sys_rst_req}));

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !eng_busy && !(wr_ctrl && bus_wdata[6]) |=> !op_start);

  p_optwe_by_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(opt_wr_en) |-> $past(wr_okey && bus_wdata == OPT_KEY2 && !locked));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_ie && !err_ie |=> !irq);
endmodule

// File: tb/flash_ctl_regs_test.sv
module flash_ctl_regs_test;
  localparam logic [31:0] K1 = 32'h3C5A_96E1, K2 = 32'hC3A5_691E;
  localparam logic [31:0] OK1 = 32'h0F1E_2D3C, OK2 = 32'hF0E1_D2C3;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_busy = 0, eng_eop = 0, eng_prog_err = 0, eng_wprot_err = 0;
  logic op_prog, op_page_erase, op_mass_erase, op_opt_prog, op_opt_erase;
  logic op_start, locked, opt_wr_en, irq, sys_rst_req;
  int total = 0, bad = 0;
  logic rd_pend = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  flash_ctl_regs uut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rd_pend) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(bus_rdata === e, t, bus_rdata, e);
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(input logic [31:0] e, input string t);
    bus_addr = 4'h8; exp_q.push_back(e); tag_q.push_back(t); rd_pend = 1;
    @(posedge clk); #1;
    rd_pend = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    rd(32'h80, "R1 reset value");
    chk(locked && !irq && !sys_rst_req, "R1 reset outputs", {locked, irq, sys_rst_req}, 3'b100);

    wr(4'h8, 32'h0000_367F);
    rd(32'h80, "R6 locked write ignored, R3 zero keeps lock");

    wr(4'h4, OK1); wr(4'h4, OK2);
    rd(32'h80, "R8 option key ignored while locked");

    wr(4'h0, K1); wr(4'h0, K2);
    rd(32'h0, "R4 unlock");

    wr(4'h8, 32'h1); rd(32'h1, "R9 program bit 0");
    chk(op_prog, "R9 op_prog output", op_prog, 1);
    wr(4'h8, 32'h2); rd(32'h2, "R9 page erase bit 1");
    chk(op_page_erase && !op_prog, "R9 op_page_erase output", op_page_erase, 1);
    wr(4'h8, 32'h4); rd(32'h4, "R9 mass erase bit 2");
    chk(op_mass_erase, "R9 op_mass_erase output", op_mass_erase, 1);
    wr(4'h8, 32'h10); rd(32'h10, "R9 option program bit 4");
    chk(op_opt_prog, "R9 op_opt_prog output", op_opt_prog, 1);
    wr(4'h8, 32'h20); rd(32'h20, "R9 option erase bit 5");
    chk(op_opt_erase, "R9 op_opt_erase output", op_opt_erase, 1);

    wr(4'h8, 32'hFFFF_C908);
    rd(32'h0, "R2 reserved bits");

    eng_busy = 1;
    wr(4'h8, 32'h40); rd(32'h40, "R7 start set");
    wr(4'h8, 32'h0); rd(32'h40, "R7 zero write keeps start");
    eng_busy = 0;
    @(posedge clk); #1;
    rd(32'h0, "R7 start cleared by busy fall");

    wr(4'h4, OK2); rd(32'h0, "R8 lone second option key");
    wr(4'h4, OK1); wr(4'h4, OK2); rd(32'h200, "R8 option enable set");
    wr(4'h8, 32'h200); rd(32'h200, "R8 write one keeps enable");
    wr(4'h8, 32'h0); rd(32'h0, "R8 write zero clears enable");

    wr(4'h8, 32'h1000);
    eng_eop = 1; @(posedge clk); #1;
    chk(irq, "R10 eop irq", irq, 1);
    eng_eop = 0; @(posedge clk); #1;
    chk(!irq, "R10 irq drops", irq, 0);
    wr(4'h8, 32'h400);
    eng_eop = 1; @(posedge clk); #1;
    chk(!irq, "R10 eop masked", irq, 0);
    eng_eop = 0; eng_prog_err = 1; @(posedge clk); #1;
    chk(irq, "R10 program error irq", irq, 1);
    eng_prog_err = 0; eng_wprot_err = 1; @(posedge clk); #1;
    chk(irq, "R10 protect error irq", irq, 1);
    eng_wprot_err = 0; @(posedge clk); #1;
    chk(!irq, "R10 irq clears", irq, 0);

    wr(4'h8, 32'h80); rd(32'h80, "R3 lock set by write");
    wr(4'h0, K2); wr(4'h0, K1); wr(4'h0, K2);
    rd(32'h80, "R5 failed attempt stays locked");
    do_reset();
    wr(4'h0, K1); wr(4'h0, K1); wr(4'h0, K1); wr(4'h0, K2);
    rd(32'h80, "R5 double first key fails");
    do_reset();
    wr(4'h0, K1); wr(4'h0, K2);
    rd(32'h0, "R5 unlock works after reset");

    wr(4'h8, 32'h2000);
    rd(32'h2000, "R11 reload bit");
    chk(sys_rst_req, "R11 reset request", sys_rst_req, 1);
    wr(4'h8, 32'h0);
    chk(sys_rst_req, "R11 request held", sys_rst_req, 1);

    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule